// File: doc/BRIEF.md
# Instruction cache control register block

This block is the software-facing control and status unit of a small instruction cache. A processor reaches it over a plain 32-bit register bus with a select, a write flag, a byte address and read/write data. Reads are combinational and writes take effect on the clock edge. The block holds the cache's control settings. It starts the cache's enable, disable and whole-cache invalidate sequences with one-cycle start strobes. The cache datapath reports the end of each sequence with a one-cycle done strobe.

Each completion, and each failed line fill, sets its own sticky status bit. Software polls these bits and clears them with a write-one-to-clear mask. An enable mask decides which status bits drive the single interrupt line. The block also counts hits, misses and uncached accesses while statistics are switched on. It keeps the address of the most recent failed fill and reports the cache's build options in a read-only parameter word.

Top module: `icache_ctl`

## Requirements
- R1: After reset the control word, status, interrupt enable, fill-error address and all counters read zero, and the interrupt line and all start strobes are low.
- R2: Offset 0x000 reads the parameter word: bits [3:0] hold SIZE_CODE (9 to 14 mean 512 B to 16 KB, other values are reserved), bit 4 is HAS_STATS and bit 5 is HAS_LINE_INV. Writes to it have no effect.
- R3: The control word at 0x004 stores bit 0 (enable), bit 1 (single-line invalidate), bit 3 (statistics enable) and bit 5 (handler allocation). The outputs cacheEnable, lineInvEnable and allocHandler follow bits 0, 1 and 5. Bits 2 and 4 always read back as zero.
- R4: A control write that changes bit 0 from 0 to 1 raises enStart for exactly the one cycle after the write edge. A write that changes it from 1 to 0 raises disStart the same way. A write that leaves bit 0 unchanged raises neither.
- R5: A control write with bit 2 set raises invStart for the one cycle after the write edge.
- R6: The status word at 0x100 has bit 0 set by invDone, bit 1 by enDone, bit 2 by disDone and bit 3 by fillErr. Each bit stays set until it is cleared.
- R7: A write to 0x104 clears exactly the status bits that are set in the written mask. Offset 0x104 reads zero.
- R8: When a status event arrives in the same cycle as a clear of that bit, the bit stays set.
- R9: The interrupt enable register at 0x108 has the status bit layout. irq is high whenever the AND of status and enable is nonzero.
- R10: Offset 0x10C reads fillErrAddr as captured on the most recent fillErr strobe.
- R11: The hit, miss and uncached counters at 0x300, 0x304 and 0x308 add one for each cycle with accHit, accMiss or accUncached high, but only while control bit 3 is set.
- R12: A control write with bit 4 set zeroes all three counters. This takes priority over an increment in the same cycle.
- R13: Each counter is CNT_W bits wide, zero-extended on read. It saturates at 2^CNT_W-1 and does not wrap.
- R14: Reads of unmapped offsets return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Register access select |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| cacheEnable | output | 1 | Enable level to the cache |
| lineInvEnable | output | 1 | Single-line invalidate enable level |
| allocHandler | output | 1 | Allocation policy level |
| enStart | output | 1 | Enable sequence start strobe |
| disStart | output | 1 | Disable sequence start strobe |
| invStart | output | 1 | Full invalidate start strobe |
| enDone | input | 1 | Enable sequence finished |
| disDone | input | 1 | Disable sequence finished |
| invDone | input | 1 | Full invalidate finished |
| fillErr | input | 1 | Line fill failed |
| fillErrAddr | input | 32 | Address of the failing fill |
| accHit | input | 1 | Access hit pulse |
| accMiss | input | 1 | Access miss pulse |
| accUncached | input | 1 | Uncached access pulse |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest cases to reach are the cases where two sources act on the same state in one clock cycle. One is a done strobe landing on the edge that also clears its status bit. The other is an access pulse landing on the edge that clears the counters. The bench reaches both by driving the cache-side strobe at the same falling edge that sets up the bus write, so both are sampled by the same rising edge. Counter saturation is reached by building the bench with a narrow counter width and holding the hit pulse for more cycles than the counter can count.

// File: rtl/icache_ctl_pkg.sv
package icache_ctl_pkg;
  // register byte offsets
  localparam int OFF_PARAM = 'h000;
  localparam int OFF_CTRL  = 'h004;
  localparam int OFF_STAT  = 'h100;
  localparam int OFF_CLR   = 'h104;
  localparam int OFF_IEN   = 'h108;
  localparam int OFF_FADDR = 'h10C;
  localparam int OFF_HIT   = 'h300;
  localparam int OFF_MISS  = 'h304;
  localparam int OFF_UNC   = 'h308;

  // control bits
  localparam int C_EN    = 0;
  localparam int C_LINV  = 1;
  localparam int C_FINV  = 2;
  localparam int C_STEN  = 3;
  localparam int C_STCLR = 4;
  localparam int C_ALLOC = 5;
  localparam int CTRL_W  = 6;

  // status bits
  localparam int S_INV   = 0;
  localparam int S_EN    = 1;
  localparam int S_DIS   = 2;
  localparam int S_FERR  = 3;
  localparam int NUM_EVT = 4;

  localparam int NUM_CNT = 3;

  typedef struct packed {
    logic statEn;
    logic statClr;
    logic fillCap;
  } statCmd_t;
endpackage

// File: rtl/icache_ctl_stats.sv
module icache_ctl_stats
  import icache_ctl_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int HAS_STATS = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  statCmd_t                      cmd,
  input  logic [NUM_CNT-1:0]            accPulse,
  input  logic [31:0]                   fillErrAddr,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  output logic [31:0]                   fillAddr
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fillAddr <= '0;
    else if (cmd.fillCap) fillAddr <= fillErrAddr;
  end

  generate
    if (HAS_STATS != 0) begin : g_stats
      for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) cntVal[g] <= '0;
          else if (cmd.statClr) cntVal[g] <= '0;
          else if (cmd.statEn && accPulse[g] && cntVal[g] != CNT_MAX)
            cntVal[g] <= cntVal[g] + 1'b1;
        end
      end
    end else begin : g_noStats
      logic unusedAcc;
      assign unusedAcc = ^{accPulse, cmd.statEn, cmd.statClr};
      assign cntVal = '0;
    end
  endgenerate
endmodule

// File: rtl/icache_ctl_regs.sv
module icache_ctl_regs
  import icache_ctl_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int CNT_W        = 32,
  parameter int SIZE_CODE    = 11,
  parameter int HAS_STATS    = 1,
  parameter int HAS_LINE_INV = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busSel,
  input  logic                          busWrite,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [31:0]                   busWdata,
  output logic [31:0]                   busRdata,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  input  logic [31:0]                   fillAddr,
  input  logic                          enDone,
  input  logic                          disDone,
  input  logic                          invDone,
  input  logic                          fillErr,
  output statCmd_t                      cmd,
  output logic                          cacheEnable,
  output logic                          lineInvEnable,
  output logic                          allocHandler,
  output logic                          enStart,
  output logic                          disStart,
  output logic                          invStart,
  output logic                          irq
);
  localparam int WI_W = ADDR_W - 2;
  localparam logic [31:0] PARAM_WORD =
    {26'd0, 1'(HAS_LINE_INV), 1'(HAS_STATS), 4'(SIZE_CODE)};
  localparam logic [CTRL_W-1:0] CTRL_KEEP =
    CTRL_W'((1 << C_EN) | (1 << C_LINV) | (1 << C_STEN) | (1 << C_ALLOC));

  logic [WI_W-1:0]    wordIdx;
  logic               wrEn, wrCtrl, wrClr, wrIen;
  logic [CTRL_W-1:0]  ctrlQ;
  logic [NUM_EVT-1:0] statusQ, ienQ, evt, clrMask;
  logic               unusedBits;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign wrEn    = busSel && busWrite;
  assign wrCtrl  = wrEn && wordIdx == WI_W'(OFF_CTRL >> 2);
  assign wrClr   = wrEn && wordIdx == WI_W'(OFF_CLR >> 2);
  assign wrIen   = wrEn && wordIdx == WI_W'(OFF_IEN >> 2);
  assign unusedBits = ^{busAddr[1:0], busWdata[31:CTRL_W]};

  // control word and start strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      enStart  <= 1'b0;
      disStart <= 1'b0;
      invStart <= 1'b0;
    end else begin
      enStart  <= wrCtrl && busWdata[C_EN] && !ctrlQ[C_EN];
      disStart <= wrCtrl && !busWdata[C_EN] && ctrlQ[C_EN];
      invStart <= wrCtrl && busWdata[C_FINV];
      if (wrCtrl) ctrlQ <= busWdata[CTRL_W-1:0] & CTRL_KEEP;
    end
  end

  // sticky status, events win over clears
  always_comb begin
    evt = '0;
    evt[S_INV]  = invDone;
    evt[S_EN]   = enDone;
    evt[S_DIS]  = disDone;
    evt[S_FERR] = fillErr;
    clrMask = wrClr ? busWdata[NUM_EVT-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      ienQ    <= '0;
    end else begin
      statusQ <= (statusQ & ~clrMask) | evt;
      if (wrIen) ienQ <= busWdata[NUM_EVT-1:0];
    end
  end

  assign irq           = |(statusQ & ienQ);
  assign cacheEnable   = ctrlQ[C_EN];
  assign lineInvEnable = ctrlQ[C_LINV];
  assign allocHandler  = ctrlQ[C_ALLOC];

  assign cmd.statEn  = ctrlQ[C_STEN];
  assign cmd.statClr = wrCtrl && busWdata[C_STCLR];
  assign cmd.fillCap = fillErr;

  // read mux
  always_comb begin
    busRdata = '0;
    if (busSel && !busWrite) begin
      case (wordIdx)
        WI_W'(OFF_PARAM >> 2): busRdata = PARAM_WORD;
        WI_W'(OFF_CTRL >> 2):  busRdata = 32'(ctrlQ);
        WI_W'(OFF_STAT >> 2):  busRdata = 32'(statusQ);
        WI_W'(OFF_IEN >> 2):   busRdata = 32'(ienQ);
        WI_W'(OFF_FADDR >> 2): busRdata = fillAddr;
        WI_W'(OFF_HIT >> 2):   busRdata = 32'(cntVal[0]);
        WI_W'(OFF_MISS >> 2):  busRdata = 32'(cntVal[1]);
        WI_W'(OFF_UNC >> 2):   busRdata = 32'(cntVal[2]);
        default:               busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/icache_ctl.sv
module icache_ctl
  import icache_ctl_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int CNT_W        = 32,
  parameter int SIZE_CODE    = 11,
  parameter int HAS_STATS    = 1,
  parameter int HAS_LINE_INV = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              cacheEnable,
  output logic              lineInvEnable,
  output logic              allocHandler,
  output logic              enStart,
  output logic              disStart,
  output logic              invStart,
  input  logic              enDone,
  input  logic              disDone,
  input  logic              invDone,
  input  logic              fillErr,
  input  logic [31:0]       fillErrAddr,
  input  logic              accHit,
  input  logic              accMiss,
  input  logic              accUncached,
  output logic              irq
);
  statCmd_t                      cmd;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal;
  logic [31:0]                   fillAddr;

  icache_ctl_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SIZE_CODE(SIZE_CODE),
    .HAS_STATS(HAS_STATS), .HAS_LINE_INV(HAS_LINE_INV)
  ) i_regs (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .cntVal(cntVal), .fillAddr(fillAddr), .enDone(enDone),
    .disDone(disDone), .invDone(invDone), .fillErr(fillErr), .cmd(cmd),
    .cacheEnable(cacheEnable), .lineInvEnable(lineInvEnable),
    .allocHandler(allocHandler), .enStart(enStart), .disStart(disStart),
    .invStart(invStart), .irq(irq)
  );

  icache_ctl_stats #(.CNT_W(CNT_W), .HAS_STATS(HAS_STATS)) i_stats (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .accPulse({accUncached, accMiss, accHit}),
    .fillErrAddr(fillErrAddr), .cntVal(cntVal), .fillAddr(fillAddr)
  );
endmodule

// File: rtl/icache_ctl_chk.sv
module icache_ctl_chk (
  input logic clk,
  input logic rstN,
  input logic busSel,
  input logic busWrite,
  input logic cacheEnable,
  input logic enStart,
  input logic disStart,
  input logic enDone,
  input logic disDone,
  input logic invDone,
  input logic fillErr,
  input logic irq
);
  // R4: the two sequence strobes never coincide
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({enStart, disStart}));

  // R4: an enable strobe lasts one cycle
  assert_en_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    enStart |=> !enStart);

  // R4: strobes agree with the enable level they announce
  assert_en_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    enStart |-> cacheEnable);
  assert_dis_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    disStart |-> !cacheEnable);

  // R3: the enable level only rises together with its start strobe
  assert_rise_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cacheEnable) |-> enStart);

  // R9: the interrupt rises only after an event or a register write
  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(enDone || disDone || invDone || fillErr
                         || (busSel && busWrite)));
endmodule

bind icache_ctl icache_ctl_chk i_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .cacheEnable(cacheEnable), .enStart(enStart), .disStart(disStart),
  .enDone(enDone), .disDone(disDone), .invDone(invDone),
  .fillErr(fillErr), .irq(irq)
);

// File: tb/test_icache_ctl.sv
module test_icache_ctl;
  localparam int CW = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        cacheEnable, lineInvEnable, allocHandler;
  logic        enStart, disStart, invStart, irq;
  logic        enDone = 0, disDone = 0, invDone = 0, fillErr = 0;
  logic [31:0] fillErrAddr = '0;
  logic        accHit = 0, accMiss = 0, accUncached = 0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  icache_ctl #(.CNT_W(CW), .SIZE_CODE(11), .HAS_STATS(1), .HAS_LINE_INV(1))
  i_icache_ctl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .cacheEnable(cacheEnable), .lineInvEnable(lineInvEnable),
    .allocHandler(allocHandler), .enStart(enStart), .disStart(disStart),
    .invStart(invStart), .enDone(enDone), .disDone(disDone),
    .invDone(invDone), .fillErr(fillErr), .fillErrAddr(fillErrAddr),
    .accHit(accHit), .accMiss(accMiss), .accUncached(accUncached),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic busRd(input logic [11:0] a, output logic [31:0] d);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    busSel = 0;
  endtask

  task automatic expectReg(input string req, input logic [11:0] a,
                           input logic [31:0] exp);
    logic [31:0] v;
    busRd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    expectReg("R1 ctrl", 12'h004, 0);
    expectReg("R1 status", 12'h100, 0);
    expectReg("R1 ien", 12'h108, 0);
    expectReg("R1 faddr", 12'h10C, 0);
    expectReg("R1 hit", 12'h300, 0);
    expectReg("R1 miss", 12'h304, 0);
    expectReg("R1 unc", 12'h308, 0);
    check("R1 outs", {irq, enStart, disStart, invStart, cacheEnable}, 0);
    expectReg("R2 param", 12'h000, 32'h3B);
  endtask

  task automatic t_params;
    busWr(12'h000, 32'hFFFF_FFFF);
    expectReg("R2 param after write", 12'h000, 32'h3B);
  endtask

  task automatic t_ctrl;
    busWr(12'h004, 32'h3F);
    check("R4 enStart", enStart, 1);
    check("R5 invStart", invStart, 1);
    check("R4 no disStart", disStart, 0);
    check("R3 levels", {cacheEnable, lineInvEnable, allocHandler}, 3'b111);
    expectReg("R3 readback", 12'h004, 32'h2B);
    @(negedge clk);
    check("R4 enStart one cycle", enStart, 0);
    check("R5 invStart one cycle", invStart, 0);
    busWr(12'h004, 32'h2B);
    check("R4 same value no strobe", {enStart, disStart}, 0);
    busWr(12'h004, 32'h00);
    check("R4 disStart", {disStart, enStart, cacheEnable}, 3'b100);
    @(negedge clk);
    check("R4 disStart one cycle", disStart, 0);
  endtask

  task automatic pulseEvt(input int which, input logic [31:0] addr);
    @(negedge clk);
    case (which)
      0: invDone = 1;
      1: enDone = 1;
      2: disDone = 1;
      default: begin fillErr = 1; fillErrAddr = addr; end
    endcase
    @(negedge clk);
    invDone = 0; enDone = 0; disDone = 0; fillErr = 0;
  endtask

  task automatic t_status;
    pulseEvt(1, 0);
    expectReg("R6 enable done", 12'h100, 32'h2);
    pulseEvt(2, 0);
    expectReg("R6 disable done", 12'h100, 32'h6);
    pulseEvt(0, 0);
    expectReg("R6 invalidate done", 12'h100, 32'h7);
    pulseEvt(3, 32'h1234_5678);
    expectReg("R6 fill error", 12'h100, 32'hF);
    expectReg("R10 first addr", 12'h10C, 32'h1234_5678);
    pulseEvt(3, 32'hCAFE_0000);
    expectReg("R10 latest addr", 12'h10C, 32'hCAFE_0000);
    check("R9 masked off", irq, 0);
    busWr(12'h108, 32'h4);
    check("R9 irq on", irq, 1);
    expectReg("R9 ien readback", 12'h108, 32'h4);
    busWr(12'h104, 32'h5);
    expectReg("R7 mask clear", 12'h100, 32'hA);
    check("R9 irq off after clear", irq, 0);
    expectReg("R7 clear reads zero", 12'h104, 0);
    // event and clear of the same bit in one cycle
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = 12'h104; busWdata = 32'h2;
    enDone = 1;
    @(negedge clk);
    busSel = 0; busWrite = 0; enDone = 0;
    expectReg("R8 event beats clear", 12'h100, 32'hA);
    busWr(12'h104, 32'hF);
    expectReg("R7 clear all", 12'h100, 0);
  endtask

  task automatic holdAcc(input int which, input int n);
    @(negedge clk);
    case (which)
      0: accHit = 1;
      1: accMiss = 1;
      default: accUncached = 1;
    endcase
    repeat (n) @(negedge clk);
    accHit = 0; accMiss = 0; accUncached = 0;
  endtask

  task automatic t_stats;
    holdAcc(0, 2);
    expectReg("R11 gated off", 12'h300, 0);
    busWr(12'h004, 32'h08);
    holdAcc(0, 3);
    holdAcc(1, 2);
    holdAcc(2, 1);
    expectReg("R11 hit", 12'h300, 3);
    expectReg("R11 miss", 12'h304, 2);
    expectReg("R11 unc", 12'h308, 1);
    busWr(12'h004, 32'h00);
    holdAcc(0, 4);
    expectReg("R11 stopped", 12'h300, 3);
    busWr(12'h004, 32'h18);
    expectReg("R12 hit cleared", 12'h300, 0);
    expectReg("R12 miss cleared", 12'h304, 0);
    expectReg("R12 unc cleared", 12'h308, 0);
    expectReg("R3 clear bit reads zero", 12'h004, 32'h08);
    holdAcc(0, 2);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = 12'h004; busWdata = 32'h18;
    accHit = 1;
    @(negedge clk);
    busSel = 0; busWrite = 0; accHit = 0;
    expectReg("R12 clear beats increment", 12'h300, 0);
    holdAcc(0, 70);
    expectReg("R13 saturate", 12'h300, 32'h3F);
    holdAcc(0, 1);
    expectReg("R13 no wrap", 12'h300, 32'h3F);
  endtask

  task automatic t_reserved;
    busWr(12'h00C, 32'hFFFF_FFFF);
    busWr(12'h200, 32'hFFFF_FFFF);
    expectReg("R14 read 0x00C", 12'h00C, 0);
    expectReg("R14 read 0x200", 12'h200, 0);
    expectReg("R14 ctrl untouched", 12'h004, 32'h08);
    expectReg("R14 ien untouched", 12'h108, 32'h4);
    expectReg("R14 hit untouched", 12'h300, 32'h3F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rstN = 1;
    @(negedge clk);
    t_params;
    t_ctrl;
    t_status;
    t_stats;
    t_reserved;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule